// File: doc/BRIEF.md
# Four-Channel TDM Voice Time-Slot Port

This block sits between a serial time-division-multiplexed voice highway and four voice channels. One serial line carries outgoing samples and one carries incoming samples. A bit clock paces both lines, and a frame-sync pulse marks where each frame begins. The block samples the bit clock, the frame sync and the receive line with the system clock. It keeps a bit counter that restarts at the frame-alignment point. From that counter it works out which 8-bit slot is on the line.

Each channel has two slot settings, one for transmit and one for receive. Each setting holds an enable bit and a slot number. While an active channel's transmit slot is on the line, the block shifts that channel's sample out MSB first, raises the output enable and pulls the active-low slot indicator low. During a channel's receive slot, the block collects eight incoming bits. It then places the byte in that channel's holding register and pulses a per-channel valid strobe. A delay-mode input chooses between two ways of aligning slot zero to frame sync. Per-channel standby inputs stop a channel from taking part in either direction.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset, tx_oe is 0, slot_ind_n is 1, tx_line is 0, rx_valid is all zeros and every rx_sample is 0. Until the first frame-sync detection, no slot activity occurs, even for enabled channels.
- R2: With delay_mode at 1, a frame sync seen high on a falling bit-clock edge, after being seen low on the falling edge before it, makes the next rising bit-clock edge the first bit of slot zero.
- R3: With delay_mode at 0, a rising bit-clock edge on which frame sync is high, after it was low on the rising edge before, is itself the first bit of slot zero.
- R4: Frame sync held high for more than one bit period restarts the frame only at its leading detection, never again while it stays high.
- R5: A slot setting byte uses bit 7 as the enable and bits 6..0 as the slot number. Slot n covers bits 8n to 8n+7 of the frame. During each of those bits of an active channel's transmit slot, tx_line carries sample bit 7 first and bit 0 last, tx_oe is 1 and slot_ind_n is 0. Outside every active transmit slot, tx_oe is 0, slot_ind_n is 1 and tx_line is 0.
- R6: A channel whose standby input is 1, or whose slot setting has bit 7 at 0, never drives the transmit line in that direction. Its rx_valid never pulses and its rx_sample keeps its previous value.
- R7: The receive line is sampled on falling bit-clock edges, MSB first, during an active channel's receive slot. After the eighth bit, the byte appears on rx_sample and rx_valid for that channel is high for exactly one system-clock cycle.
- R8: A channel's transmit sample is taken from tx_sample at the first bit of its slot. Changes to tx_sample later in that slot do not alter the bits shifted out.
- R9: The bit counter covers 1024 bits and does not wrap. Once bit 1023 has passed without a new frame sync, no slot is active until the next frame-sync detection.
- R10: When several active channels hold the same transmit slot, the lowest-numbered channel drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every serial input |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame-sync pulse |
| rx_line | input | 1 | Serial receive data |
| delay_mode | input | 1 | 1: slot zero after a falling-edge sync detection; 0: slot zero at the rising edge that sees sync |
| standby | input | NCH | Per-channel standby; 1 stops transmit and receive |
| tx_slot_cfg | input | NCH x 8 | Per-channel transmit slot setting (bit 7 enable, 6..0 slot) |
| rx_slot_cfg | input | NCH x 8 | Per-channel receive slot setting (bit 7 enable, 6..0 slot) |
| tx_sample | input | NCH x 8 | Per-channel outgoing sample |
| tx_line | output | 1 | Serial transmit data, 0 when not driven |
| tx_oe | output | 1 | High while tx_line carries an active slot |
| slot_ind_n | output | 1 | Active-low slot indicator |
| rx_sample | output | NCH x 8 | Per-channel received byte |
| rx_valid | output | NCH | One-cycle strobe when a received byte is committed |

## Verification
On every cycle the assertions check four things. Each receive strobe lasts one cycle. A holding register changes only with its strobe. A strobe or a rise of the output enable needs an enabled, non-standby channel. The bit counter only steps by one, restarts or stops at its end. Only the scenarios can show where slot zero falls under each alignment mode and that a wide sync does not restart the frame. They also show the exact bit order on both lines, the sample latched at slot start, which channel wins when slots overlap, and the silence after the counter runs out.

// File: rtl/pcm_tdm_pkg.sv
// Shared widths and types for the TDM time-slot port.
// Assumes 8-bit samples and 7-bit slot numbers, giving a 10-bit frame bit counter.
package pcm_tdm_pkg;
    localparam int SAMPLE_W  = 8;
    localparam int SLOT_W    = 7;
    localparam int BIT_IDX_W = $clog2(SAMPLE_W);
    localparam int CNT_W     = SLOT_W + BIT_IDX_W;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // One slot setting: enable flag above the slot number.
    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] num;
    } slot_cfg_t;
endpackage

// File: rtl/pcm_edge_sync.sv
// Brings bit clock, frame sync and receive data into the system clock domain
// through the same synchronizer chain, so all three stay aligned. It then flags
// rising and falling bit-clock edges as one-cycle pulses.
// Assumes the system clock is several times faster than the bit clock.
module pcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fs_in,
    input  logic dr_in,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fs_s,
    output logic dr_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][2:0] chain;
    logic                   bclk_q;

    // Purpose: shift the three raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '0;
            bclk_q <= 1'b0;
        end else begin
            chain[0] <= {bclk_in, fs_in, dr_in};
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
            bclk_q <= chain[LAST][2];
        end
    end

    assign bclk_rise = chain[LAST][2] & ~bclk_q;
    assign bclk_fall = ~chain[LAST][2] & bclk_q;
    assign fs_s      = chain[LAST][1];
    assign dr_s      = chain[LAST][0];
endmodule

// File: rtl/pcm_frame_counter.sv
// Recovers frame alignment from frame sync and counts bits within the frame.
// Delay mode arms on a fresh high seen at a falling edge and restarts at the
// next rising edge. Non-delay mode restarts at a rising edge that sees a fresh high.
// The counter stops, and drops frm_valid, after its last value.
module pcm_frame_counter
    import pcm_tdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             fs_s,
    input  logic             delay_mode,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             frm_valid,
    output logic             bit_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic fs_at_rise;
    logic fs_at_fall;
    logic armed;
    logic restart;

    assign restart = delay_mode ? armed : (fs_s & ~fs_at_rise);

    // Purpose: track sync history, restart or advance the bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_at_rise <= 1'b0;
            fs_at_fall <= 1'b0;
            armed      <= 1'b0;
            bit_cnt    <= '0;
            frm_valid  <= 1'b0;
            bit_tick   <= 1'b0;
        end else begin
            bit_tick <= bclk_rise;
            if (bclk_fall) begin
                fs_at_fall <= fs_s;
                if (delay_mode && fs_s && !fs_at_fall) begin
                    armed <= 1'b1;
                end
            end
            if (bclk_rise) begin
                fs_at_rise <= fs_s;
                armed      <= 1'b0;
                if (restart) begin
                    bit_cnt   <= '0;
                    frm_valid <= 1'b1;
                end else if (frm_valid) begin
                    if (bit_cnt == CNT_MAX) begin
                        frm_valid <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tx_serializer.sv
// Chooses the channel that owns the current transmit slot, with the lowest
// index first. It loads that channel's sample at the slot's first bit and shifts
// it out MSB first. Output enable and the active-low indicator follow the slot.
// Assumes bit_tick marks the cycle in which bit_cnt holds the new bit.
module pcm_tx_serializer
    import pcm_tdm_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_tick,
    input  logic                          frm_valid,
    input  logic [CNT_W-1:0]              bit_cnt,
    input  logic [NCH-1:0][SAMPLE_W-1:0]  slot_cfg,
    input  logic [NCH-1:0]                standby,
    input  logic [NCH-1:0][SAMPLE_W-1:0]  sample_in,
    output logic                          line_out,
    output logic                          oe,
    output logic                          ind_n
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]      hit;
    logic [CH_W-1:0]     win;
    logic [SAMPLE_W-2:0] shreg;
    logic                first_bit;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_match
        slot_cfg_t c;
        assign c       = slot_cfg_t'(slot_cfg[ch]);
        assign hit[ch] = frm_valid & c.en & ~standby[ch]
                       & (bit_cnt[CNT_W-1:BIT_IDX_W] == c.num);
    end

    // Purpose: priority pick of the lowest-numbered matching channel.
    always_comb begin
        win = '0;
        for (int ch = NCH - 1; ch >= 0; ch--) begin
            if (hit[ch]) begin
                win = CH_W'(ch);
            end
        end
    end

    assign first_bit = (bit_cnt[BIT_IDX_W-1:0] == '0);

    // Purpose: drive one bit per bit-clock rise, loading at slot start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            oe       <= 1'b0;
            ind_n    <= 1'b1;
            shreg    <= '0;
        end else if (bit_tick) begin
            if (|hit) begin
                oe    <= 1'b1;
                ind_n <= 1'b0;
                if (first_bit) begin
                    line_out <= sample_in[win][SAMPLE_W-1];
                    shreg    <= sample_in[win][SAMPLE_W-2:0];
                end else begin
                    line_out <= shreg[SAMPLE_W-2];
                    shreg    <= {shreg[SAMPLE_W-3:0], 1'b0};
                end
            end else begin
                line_out <= 1'b0;
                oe       <= 1'b0;
                ind_n    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_rx_lane.sv
// One channel's receive path. During its receive slot it shifts in a bit on
// each falling bit-clock edge. After the eighth bit it commits the byte and
// pulses valid for one cycle. Assumes bit_cnt is stable across falling edges.
module pcm_rx_lane
    import pcm_tdm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_fall,
    input  logic                dr_s,
    input  logic                frm_valid,
    input  logic [CNT_W-1:0]    bit_cnt,
    input  logic [SAMPLE_W-1:0] cfg,
    input  logic                standby,
    output sample_t             rx_data,
    output logic                rx_vld
);
    slot_cfg_t           c;
    logic                hit;
    logic [SAMPLE_W-2:0] shreg;

    assign c   = slot_cfg_t'(cfg);
    assign hit = frm_valid & c.en & ~standby
               & (bit_cnt[CNT_W-1:BIT_IDX_W] == c.num);

    // Purpose: collect slot bits and commit the byte on its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            rx_data <= '0;
            rx_vld  <= 1'b0;
        end else begin
            rx_vld <= 1'b0;
            if (bclk_fall && hit) begin
                shreg <= {shreg[SAMPLE_W-3:0], dr_s};
                if (&bit_cnt[BIT_IDX_W-1:0]) begin
                    rx_data <= {shreg, dr_s};
                    rx_vld  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tdm_port.sv
// Top of the four-channel TDM time-slot port. It wires the synchronizer, the
// frame counter, the shared transmit serializer and one receive lane per
// channel. Slot settings, delay mode and standby are static inputs that the
// surrounding logic holds steady across a frame.
module pcm_tdm_port
    import pcm_tdm_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bclk,
    input  logic                         fsync,
    input  logic                         rx_line,
    input  logic                         delay_mode,
    input  logic [NCH-1:0]               standby,
    input  logic [NCH-1:0][SAMPLE_W-1:0] tx_slot_cfg,
    input  logic [NCH-1:0][SAMPLE_W-1:0] rx_slot_cfg,
    input  logic [NCH-1:0][SAMPLE_W-1:0] tx_sample,
    output logic                         tx_line,
    output logic                         tx_oe,
    output logic                         slot_ind_n,
    output logic [NCH-1:0][SAMPLE_W-1:0] rx_sample,
    output logic [NCH-1:0]               rx_valid
);
    logic             bclk_rise;
    logic             bclk_fall;
    logic             fs_s;
    logic             dr_s;
    logic [CNT_W-1:0] bit_cnt;
    logic             frm_valid;
    logic             bit_tick;

    pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_in   (bclk),
        .fs_in     (fsync),
        .dr_in     (rx_line),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .fs_s      (fs_s),
        .dr_s      (dr_s)
    );

    pcm_frame_counter u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .fs_s       (fs_s),
        .delay_mode (delay_mode),
        .bit_cnt    (bit_cnt),
        .frm_valid  (frm_valid),
        .bit_tick   (bit_tick)
    );

    pcm_tx_serializer #(.NCH(NCH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .frm_valid (frm_valid),
        .bit_cnt   (bit_cnt),
        .slot_cfg  (tx_slot_cfg),
        .standby   (standby),
        .sample_in (tx_sample),
        .line_out  (tx_line),
        .oe        (tx_oe),
        .ind_n     (slot_ind_n)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_rx
        pcm_rx_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .bclk_fall (bclk_fall),
            .dr_s      (dr_s),
            .frm_valid (frm_valid),
            .bit_cnt   (bit_cnt),
            .cfg       (rx_slot_cfg[ch]),
            .standby   (standby[ch]),
            .rx_data   (rx_sample[ch]),
            .rx_vld    (rx_valid[ch])
        );
    end
endmodule

// File: rtl/pcm_tdm_port_chk.sv
// Property checker for pcm_tdm_port, attached by bind. It watches the receive
// strobes and holding registers, the transmit enable and the internal bit counter.
module pcm_tdm_port_chk
    import pcm_tdm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NCH-1:0]               standby,
    input logic [NCH-1:0][SAMPLE_W-1:0] tx_slot_cfg,
    input logic [NCH-1:0][SAMPLE_W-1:0] rx_slot_cfg,
    input logic                         tx_oe,
    input logic [NCH-1:0][SAMPLE_W-1:0] rx_sample,
    input logic [NCH-1:0]               rx_valid,
    input logic [CNT_W-1:0]             bit_cnt,
    input logic                         frm_valid
);
    logic [NCH-1:0] tx_live;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign tx_live[i] = tx_slot_cfg[i][SAMPLE_W-1] & ~standby[i];

        // R7: the commit strobe lasts exactly one cycle
        p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[i] |=> !rx_valid[i]);

        // R6: a holding register moves only together with its strobe
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_valid[i] |-> $stable(rx_sample[i]));

        // R6: a strobe needs an enabled channel out of standby
        p_rx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[i] |-> $past(rx_slot_cfg[i][SAMPLE_W-1] & ~standby[i]));
    end

    // R5: the output enable rises only when some transmit channel is live
    p_tx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> $past(|tx_live));

    // R9: inside a frame the counter steps by one or restarts at zero
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && $past(frm_valid) && (bit_cnt != $past(bit_cnt)))
        |-> ((bit_cnt == CNT_W'($past(bit_cnt) + 1'b1)) || (bit_cnt == '0)));

    // R9: from its last value the counter never steps to anything but a restart
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frm_valid) && ($past(bit_cnt) == '1) && frm_valid)
        |-> ((bit_cnt == '1) || (bit_cnt == '0)));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby     (standby),
    .tx_slot_cfg (tx_slot_cfg),
    .rx_slot_cfg (rx_slot_cfg),
    .tx_oe       (tx_oe),
    .rx_sample   (rx_sample),
    .rx_valid    (rx_valid),
    .bit_cnt     (bit_cnt),
    .frm_valid   (frm_valid)
);

// File: tb/tb_pcm_tdm_port.sv
// Directed bench for pcm_tdm_port: one task per scenario, each checking itself.
// One bit period is 12 system clocks: 6 with bclk high, then 6 with it low.
module tb_pcm_tdm_port;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic fsync = 1'b0;
    logic rx_line = 1'b0;
    logic delay_mode = 1'b1;
    logic [NCH-1:0]        standby = '0;
    logic [NCH-1:0][7:0]   tx_slot_cfg = '0;
    logic [NCH-1:0][7:0]   rx_slot_cfg = '0;
    logic [NCH-1:0][7:0]   tx_sample = '0;
    logic                  tx_line;
    logic                  tx_oe;
    logic                  slot_ind_n;
    logic [NCH-1:0][7:0]   rx_sample;
    logic [NCH-1:0]        rx_valid;

    int checks = 0;
    int fails = 0;
    int vcnt [NCH] = '{default: 0};
    logic [7:0] seed = 8'h00;

    always #10 clk = ~clk;

    pcm_tdm_port #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rx_line(rx_line),
        .delay_mode(delay_mode), .standby(standby), .tx_slot_cfg(tx_slot_cfg),
        .rx_slot_cfg(rx_slot_cfg), .tx_sample(tx_sample), .tx_line(tx_line),
        .tx_oe(tx_oe), .slot_ind_n(slot_ind_n), .rx_sample(rx_sample),
        .rx_valid(rx_valid)
    );

    // Counts receive strobes per channel, away from the active edge.
    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rx_valid[i]) vcnt[i] = vcnt[i] + 1;
        end
    end

    function automatic logic [7:0] pat(input int s);
        return 8'(s * 29) ^ seed;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // One bit period; returns {tx_oe, slot_ind_n, tx_line} late in the low phase.
    task automatic drive_bit(input logic fa, input logic fb, input logic d,
                             output logic [2:0] obs);
        @(negedge clk);
        bclk = 1'b1; fsync = fa; rx_line = d;
        repeat (6) @(negedge clk);
        bclk = 1'b0; fsync = fb;
        repeat (5) @(negedge clk);
        obs = {tx_oe, slot_ind_n, tx_line};
    endtask

    // Drives one frame and checks every transmit bit and each channel's receive result.
    task automatic run_frame(input int nbits, input bit dly, input bit next_dly,
                             input bit wide, input string tag,
                             input int chg_bit, input logic [7:0] chg_val);
        logic [7:0] lat [NCH];
        int         snap_cnt [NCH];
        logic [7:0] snap_dat [NCH];
        logic       fa, fb, d, hit;
        logic [2:0] obs, exp_o;
        logic [7:0] byte_v;
        int         w, s;
        delay_mode = dly;
        for (int ch = 0; ch < NCH; ch++) begin
            snap_cnt[ch] = vcnt[ch];
            snap_dat[ch] = rx_sample[ch];
            lat[ch] = 8'h00;
        end
        for (int b = 0; b < nbits; b++) begin
            fa = 1'b0; fb = 1'b0;
            if (b == 0) begin fa = dly ? wide : 1'b1; fb = wide; end
            if (b == 1 && wide && !dly) fa = 1'b1;
            if (b == nbits - 1) begin fa = next_dly; fb = next_dly; end
            if (b == chg_bit) tx_sample[0] = chg_val;
            if (b % 8 == 0) begin
                for (int ch = 0; ch < NCH; ch++) lat[ch] = tx_sample[ch];
            end
            w = -1;
            if (b < 1024) begin
                for (int ch = NCH - 1; ch >= 0; ch--) begin
                    if (tx_slot_cfg[ch][7] && !standby[ch] &&
                        int'(tx_slot_cfg[ch][6:0]) == b / 8) w = ch;
                end
            end
            exp_o = (w >= 0) ? {1'b1, 1'b0, lat[w][7 - (b % 8)]} : 3'b010;
            byte_v = pat(b / 8);
            d = byte_v[7 - (b % 8)];
            drive_bit(fa, fb, d, obs);
            check(tag, 32'(obs), 32'(exp_o), $sformatf("bit %0d {oe,ind_n,line}", b));
        end
        repeat (3) @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            s = int'(rx_slot_cfg[ch][6:0]);
            hit = rx_slot_cfg[ch][7] && !standby[ch] && (s * 8 + 7 < nbits) && (s * 8 + 7 < 1024);
            if (hit) begin
                check(tag, 32'(vcnt[ch] - snap_cnt[ch]), 32'd1, $sformatf("ch%0d strobe count", ch));
                check(tag, 32'(rx_sample[ch]), 32'(pat(s)), $sformatf("ch%0d rx byte", ch));
            end else begin
                check(tag, 32'(vcnt[ch] - snap_cnt[ch]), 32'd0, $sformatf("ch%0d idle strobe count", ch));
                check(tag, 32'(rx_sample[ch]), 32'(snap_dat[ch]), $sformatf("ch%0d held byte", ch));
            end
        end
    endtask

    // R1: reset values, then no activity without a frame sync
    task automatic test_reset();
        logic [2:0] obs;
        check("R1", 32'({tx_oe, slot_ind_n, tx_line}), 32'(3'b010), "reset {oe,ind_n,line}");
        check("R1", 32'(rx_valid), 32'd0, "reset rx_valid");
        check("R1", 32'(rx_sample), 32'd0, "reset rx_sample");
        tx_slot_cfg[0] = 8'h80; rx_slot_cfg[0] = 8'h80; tx_sample[0] = 8'hFF;
        for (int b = 0; b < 16; b++) begin
            drive_bit(1'b0, 1'b0, 1'b1, obs);
            check("R1", 32'(obs), 32'(3'b010), "unsynced bit");
        end
        check("R1", 32'(vcnt[0]), 32'd0, "unsynced strobe");
        // prepare a delay-mode frame start
        drive_bit(1'b1, 1'b1, 1'b0, obs);
        check("R1", 32'(obs), 32'(3'b010), "sync bit before frame");
    endtask

    // R2 R5 R7: delay-mode frames, several slot layouts; second frame has wide sync (R4)
    task automatic test_delay();
        tx_slot_cfg = {8'h85, 8'h87, 8'h80, 8'h82};
        rx_slot_cfg = {8'h87, 8'h83, 8'h86, 8'h81};
        tx_sample   = {8'h3C, 8'h81, 8'h5A, 8'hC3};
        seed = 8'h6B;
        run_frame(64, 1'b1, 1'b1, 1'b0, "R2/R5/R7", -1, 8'h00);
        tx_slot_cfg = {8'h8C, 8'h80, 8'h8F, 8'h89};
        rx_slot_cfg = {8'h80, 8'h8F, 8'h8A, 8'h84};
        tx_sample   = {8'hE1, 8'h0F, 8'h96, 8'h7E};
        seed = 8'h1D;
        run_frame(128, 1'b1, 1'b1, 1'b1, "R4/R2/R5/R7", -1, 8'h00);
    endtask

    // R6: standby and cleared enable bits silence both directions
    task automatic test_disabled();
        standby     = 4'b0110;
        tx_slot_cfg = {8'h03, 8'h82, 8'h81, 8'h84};
        rx_slot_cfg = {8'h05, 8'h83, 8'h86, 8'h81};
        tx_sample   = {8'hAA, 8'hFF, 8'hFF, 8'h69};
        seed = 8'hC4;
        run_frame(64, 1'b1, 1'b1, 1'b0, "R6", -1, 8'h00);
        standby = '0;
    endtask

    // R8: a change to the sample mid-slot is not seen on the line
    task automatic test_latch();
        tx_slot_cfg = {8'h00, 8'h00, 8'h00, 8'h82};
        rx_slot_cfg = {8'h00, 8'h00, 8'h00, 8'h82};
        tx_sample[0] = 8'hB2;
        seed = 8'h33;
        run_frame(64, 1'b1, 1'b1, 1'b0, "R8", 19, 8'h4D);
    endtask

    // R10: overlapping transmit slots go to the lowest channel
    task automatic test_overlap();
        tx_slot_cfg = {8'h84, 8'h00, 8'h84, 8'h81};
        tx_sample   = {8'hF0, 8'h00, 8'h2D, 8'h11};
        seed = 8'h5E;
        run_frame(64, 1'b1, 1'b1, 1'b0, "R10", -1, 8'h00);
    endtask

    // R9: a long frame reaches slot 127 once and then stays silent
    task automatic test_long();
        tx_slot_cfg = {8'h00, 8'h00, 8'hFF, 8'h81};
        rx_slot_cfg = {8'h81, 8'hFF, 8'h00, 8'h00};
        tx_sample   = {8'h00, 8'h00, 8'hA7, 8'h5C};
        seed = 8'h92;
        run_frame(1040, 1'b1, 1'b0, 1'b0, "R9", -1, 8'h00);
    endtask

    // R3: non-delay frames, normal then wide sync (R4)
    task automatic test_nondelay();
        tx_slot_cfg = {8'h86, 8'h80, 8'h83, 8'h87};
        rx_slot_cfg = {8'h82, 8'h87, 8'h80, 8'h85};
        tx_sample   = {8'h1B, 8'hD4, 8'h66, 8'h99};
        seed = 8'h48;
        run_frame(64, 1'b0, 1'b0, 1'b0, "R3/R5/R7", -1, 8'h00);
        seed = 8'hE7;
        run_frame(64, 1'b0, 1'b0, 1'b1, "R4/R3", -1, 8'h00);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-timeout act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_delay();
        test_disabled();
        test_latch();
        test_overlap();
        test_long();
        test_nondelay();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule